// File: doc/BRIEF.md
# Conditional Subroutine Call Stack Unit

This block is the call and return part of the program sequencer of a small 4-bit controller. It holds the program counter, made of a 4-bit page field and a 6-bit address field, together with a four-level return stack. A short call jumps into page 0. A page-preload instruction placed directly before the short call redirects that one call to any page, so the pair acts as a long call. Interrupt entry shares the same stack levels as subroutine calls.

Calls depend on a one-bit status flag. When the flag is clear, a call is not taken. The program counter simply advances and the flag is set again. A preload made while the flag is clear cancels the call that follows it, so the whole long-call pair is skipped. The instruction decoder in front of the block gives one strobe per instruction class and a 6-bit operand. The block updates all of its state on the next clock edge.

Top module: `call_stack_unit`

## Requirements
- R1: During and after synchronous reset, and before any instruction, o_pc is 0, all four stack levels are 0 and o_flag is 1.
- R2: An advance instruction adds 1 to the address field (o_pc bits 5..0), wrapping from 63 to 0, and leaves the page field (bits 9..6) unchanged.
- R3: A short call taken with the flag at 1 and no preload armed loads page 0 and sets the address field to the operand. The flag stays 1.
- R4: A taken call writes the current PC advanced as in R2 into level 1 (o_stack bits 9..0). Levels 1 to 3 move down to levels 2 to 4 in the same edge, and the old level 4 value is discarded without any error.
- R5: A call issued with the flag at 0 only advances the PC as in R2, leaves the stack unchanged and sets the flag to 1.
- R6: A preload issued with the flag at 1 advances the PC and arms the operand's low 4 bits as the page of the next call. This applies only to the instruction directly after it. Any other instruction clears it, and later calls go back to page 0.
- R7: A preload issued with the flag at 0 advances the PC and sets the flag to 1. A call directly after it is then skipped as in R5.
- R8: A return loads the PC from level 1 and moves levels 2 to 4 up by one. Level 4 keeps its old value.
- R9: An interrupt entry is taken whatever the flag is. It pushes the current PC, not advanced, as in R4, loads page 0 with the operand as address, and leaves the flag unchanged.
- R10: A flag-write instruction loads o_flag from i_flag and advances the PC.
- R11: When several strobes are high, only one takes effect, in this order of precedence: interrupt, return, call, preload, flag-write, advance.
- R12: With no strobe high, the PC, the stack, the flag and any armed preload or pending skip hold their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| i_adv | input | 1 | Plain instruction: advance the PC |
| i_setf | input | 1 | Flag-write instruction |
| i_lpu | input | 1 | Page-preload instruction |
| i_call | input | 1 | Short call instruction |
| i_ret | input | 1 | Return instruction |
| i_irq | input | 1 | Interrupt entry |
| i_opnd | input | 6 | Operand: call target, preload page (bits 3..0) or interrupt vector |
| i_flag | input | 1 | Value for the flag-write instruction |
| o_pc | output | 10 | Program counter, {page, address} |
| o_stack | output | 40 | Stack levels, level 1 in bits 9..0 up to level 4 in bits 39..30 |
| o_flag | output | 1 | Status flag |

## Verification
A fault in the stack shift shows on o_stack one cycle after the push or pop that caused it. It then shows on o_pc at the return that pops the wrong level. An armed preload or a pending skip cannot be seen directly, so a fault in either appears only at the next call: the page field of o_pc is wrong, or the call is taken or skipped when it should not be. For this reason the stimulus puts calls right after preloads, flag-writes and interrupts, and also after ordinary instructions.

// File: rtl/csu_pkg.sv
package csu_pkg;
    parameter int PAGE_W = 4;
    parameter int ADDR_W = 6;
    parameter int DEPTH  = 4;
    localparam int PC_W  = PAGE_W + ADDR_W;

    typedef struct packed {
        logic [PAGE_W-1:0] page;
        logic [ADDR_W-1:0] addr;
    } pc_t;

    typedef enum logic [2:0] {
        OP_NONE, OP_ADV, OP_SETF, OP_LPU, OP_CALL, OP_RET, OP_IRQ
    } op_e;

    typedef enum logic [1:0] {STK_HOLD, STK_PUSH, STK_POP} stk_e;

    // advance within the address field; the page never changes
    function automatic pc_t pc_step(pc_t p);
        pc_t r;
        r = p;
        r.addr = p.addr + 1'b1;
        return r;
    endfunction
endpackage

// File: rtl/csu_decode.sv
module csu_decode import csu_pkg::*; (
    input  logic i_adv,
    input  logic i_setf,
    input  logic i_lpu,
    input  logic i_call,
    input  logic i_ret,
    input  logic i_irq,
    output op_e  op
);
    // fixed precedence when several strobes arrive together (R11)
    always_comb begin
        if (i_irq)       op = OP_IRQ;
        else if (i_ret)  op = OP_RET;
        else if (i_call) op = OP_CALL;
        else if (i_lpu)  op = OP_LPU;
        else if (i_setf) op = OP_SETF;
        else if (i_adv)  op = OP_ADV;
        else             op = OP_NONE;
    end
endmodule

// File: rtl/csu_stack.sv
module csu_stack import csu_pkg::*; (
    input  logic clk,
    input  logic rst,
    input  stk_e cmd,
    input  pc_t  push_val,
    output pc_t  lvl [DEPTH]
);
    pc_t st_q [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_lvl
        pc_t from_above;
        pc_t from_below;
        if (i == 0) begin : g_top
            assign from_above = push_val;
        end else begin : g_mid
            assign from_above = st_q[i-1];
        end
        if (i == DEPTH - 1) begin : g_last
            assign from_below = st_q[i];
        end else begin : g_inner
            assign from_below = st_q[i+1];
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                st_q[i] <= '0;
            end else begin
                case (cmd)
                    STK_PUSH: st_q[i] <= from_above;
                    STK_POP:  st_q[i] <= from_below;
                    default:  st_q[i] <= st_q[i];
                endcase
            end
        end
        assign lvl[i] = st_q[i];
    end

    assert_push_top_R4: assert property (@(posedge clk) disable iff (rst)
        cmd == STK_PUSH |=> st_q[0] == $past(push_val));
    assert_push_shift_R4: assert property (@(posedge clk) disable iff (rst)
        cmd == STK_PUSH |=> st_q[DEPTH-1] == $past(st_q[DEPTH-2]));
    assert_pop_bottom_R8: assert property (@(posedge clk) disable iff (rst)
        cmd == STK_POP |=> st_q[DEPTH-1] == $past(st_q[DEPTH-1]));
endmodule

// File: rtl/csu_seq.sv
module csu_seq import csu_pkg::*; (
    input  logic              clk,
    input  logic              rst,
    input  op_e               op,
    input  logic [ADDR_W-1:0] opnd,
    input  logic              flag_in,
    input  pc_t               st_top,
    output pc_t               pc_o,
    output logic              flag_o,
    output stk_e              stk_cmd,
    output pc_t               push_val
);
    pc_t               pc_q, pc_d;
    logic              flag_q, flag_d;
    logic              arm_q, arm_d;
    logic              skip_q, skip_d;
    logic [PAGE_W-1:0] page_q, page_d;

    always_comb begin
        pc_d     = pc_q;
        flag_d   = flag_q;
        arm_d    = 1'b0;
        skip_d   = 1'b0;
        page_d   = page_q;
        stk_cmd  = STK_HOLD;
        push_val = pc_step(pc_q);
        case (op)
            OP_NONE: begin
                arm_d  = arm_q;
                skip_d = skip_q;
            end
            OP_ADV: pc_d = pc_step(pc_q);
            OP_SETF: begin
                pc_d   = pc_step(pc_q);
                flag_d = flag_in;
            end
            OP_LPU: begin
                pc_d = pc_step(pc_q);
                if (flag_q) begin
                    arm_d  = 1'b1;
                    page_d = opnd[PAGE_W-1:0];
                end else begin
                    flag_d = 1'b1;
                    skip_d = 1'b1;
                end
            end
            OP_CALL: begin
                if (!flag_q || skip_q) begin
                    pc_d   = pc_step(pc_q);
                    flag_d = 1'b1;
                end else begin
                    stk_cmd   = STK_PUSH;
                    pc_d.page = arm_q ? page_q : '0;
                    pc_d.addr = opnd;
                end
            end
            OP_RET: begin
                stk_cmd = STK_POP;
                pc_d    = st_top;
            end
            OP_IRQ: begin
                stk_cmd   = STK_PUSH;
                push_val  = pc_q;
                pc_d.page = '0;
                pc_d.addr = opnd;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q   <= '0;
            flag_q <= 1'b1;
            arm_q  <= 1'b0;
            skip_q <= 1'b0;
            page_q <= '0;
        end else begin
            pc_q   <= pc_d;
            flag_q <= flag_d;
            arm_q  <= arm_d;
            skip_q <= skip_d;
            page_q <= page_d;
        end
    end

    assign pc_o   = pc_q;
    assign flag_o = flag_q;

    assert_skip_sets_flag_R5: assert property (@(posedge clk) disable iff (rst)
        (op == OP_CALL && !flag_q) |=> flag_q &&
        pc_q.addr == ADDR_W'($past(pc_q.addr) + 1'b1));
    assert_default_page_R3: assert property (@(posedge clk) disable iff (rst)
        (op == OP_CALL && flag_q && !skip_q && !arm_q) |=> pc_q.page == '0);
    assert_lpu_skip_R7: assert property (@(posedge clk) disable iff (rst)
        (op == OP_LPU && !flag_q) |=> flag_q);
    assert_adv_page_R2: assert property (@(posedge clk) disable iff (rst)
        op == OP_ADV |=> pc_q.page == $past(pc_q.page));
endmodule

// File: rtl/call_stack_unit.sv
module call_stack_unit import csu_pkg::*; (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  i_adv,
    input  logic                  i_setf,
    input  logic                  i_lpu,
    input  logic                  i_call,
    input  logic                  i_ret,
    input  logic                  i_irq,
    input  logic [ADDR_W-1:0]     i_opnd,
    input  logic                  i_flag,
    output logic [PC_W-1:0]       o_pc,
    output logic [DEPTH*PC_W-1:0] o_stack,
    output logic                  o_flag
);
    op_e  op;
    stk_e stk_cmd;
    pc_t  push_val;
    pc_t  pc;
    pc_t  lvl [DEPTH];

    csu_decode u_dec (
        .i_adv (i_adv),
        .i_setf(i_setf),
        .i_lpu (i_lpu),
        .i_call(i_call),
        .i_ret (i_ret),
        .i_irq (i_irq),
        .op    (op)
    );

    csu_seq u_seq (
        .clk     (clk),
        .rst     (rst),
        .op      (op),
        .opnd    (i_opnd),
        .flag_in (i_flag),
        .st_top  (lvl[0]),
        .pc_o    (pc),
        .flag_o  (o_flag),
        .stk_cmd (stk_cmd),
        .push_val(push_val)
    );

    csu_stack u_stk (
        .clk     (clk),
        .rst     (rst),
        .cmd     (stk_cmd),
        .push_val(push_val),
        .lvl     (lvl)
    );

    assign o_pc = pc;
    for (genvar i = 0; i < DEPTH; i++) begin : g_out
        assign o_stack[i*PC_W +: PC_W] = lvl[i];
    end

    assert_ret_target_R8: assert property (@(posedge clk) disable iff (rst)
        op == OP_RET |=> pc == $past(lvl[0]));
    assert_irq_flag_R9: assert property (@(posedge clk) disable iff (rst)
        op == OP_IRQ |=> o_flag == $past(o_flag));
endmodule

// File: tb/sim_call_stack_unit.sv
`timescale 1ns/1ps
module sim_call_stack_unit;
    logic       clk = 1'b0;
    logic       rst;
    logic       adv, setf, lpu, call, ret, irq, flg;
    logic [5:0] opnd;
    logic [9:0] pc;
    logic [39:0] stk;
    logic       flag;

    int vectors = 0;
    int fails   = 0;

    // reference state
    logic [9:0] m_pc;
    logic [9:0] m_st [4];
    logic       m_flag, m_arm, m_skip;
    logic [3:0] m_page;

    always #10 clk = ~clk;

    call_stack_unit u0 (
        .clk(clk), .rst(rst), .i_adv(adv), .i_setf(setf), .i_lpu(lpu),
        .i_call(call), .i_ret(ret), .i_irq(irq), .i_opnd(opnd),
        .i_flag(flg), .o_pc(pc), .o_stack(stk), .o_flag(flag)
    );

    function automatic logic [9:0] inc(logic [9:0] p);
        return {p[9:6], 6'(p[5:0] + 6'd1)};
    endfunction

    task automatic push(logic [9:0] v);
        for (int i = 3; i > 0; i--) m_st[i] = m_st[i-1];
        m_st[0] = v;
    endtask

    task automatic compare(string req);
        logic [39:0] exp_stk;
        exp_stk = {m_st[3], m_st[2], m_st[1], m_st[0]};
        vectors++;
        if (pc !== m_pc || stk !== exp_stk || flag !== m_flag) begin
            fails++;
            $display("FAIL %s: pc=%h stack=%h flag=%b expected pc=%h stack=%h flag=%b",
                     req, pc, stk, flag, m_pc, exp_stk, m_flag);
        end
    endtask

    task automatic run(logic a, logic s, logic l, logic c, logic r, logic q,
                       logic [5:0] od, logic fv);
        string req;
        int n;
        logic arm, skp;
        @(negedge clk);
        adv = a; setf = s; lpu = l; call = c; ret = r; irq = q;
        opnd = od; flg = fv;
        n = a + s + l + c + r + q;
        arm = m_arm; skp = m_skip;
        m_arm = 1'b0; m_skip = 1'b0;
        if (q) begin
            req = "R9"; push(m_pc); m_pc = {4'd0, od};
        end else if (r) begin
            req = "R8"; m_pc = m_st[0];
            for (int i = 0; i < 3; i++) m_st[i] = m_st[i+1];
        end else if (c) begin
            if (!m_flag || skp) begin
                req = skp ? "R7" : "R5"; m_pc = inc(m_pc); m_flag = 1'b1;
            end else begin
                req = arm ? "R6/R4" : "R3/R4"; push(inc(m_pc));
                m_pc = {arm ? m_page : 4'd0, od};
            end
        end else if (l) begin
            m_pc = inc(m_pc);
            if (m_flag) begin req = "R6"; m_arm = 1'b1; m_page = od[3:0]; end
            else begin req = "R7"; m_flag = 1'b1; m_skip = 1'b1; end
        end else if (s) begin
            req = "R10"; m_pc = inc(m_pc); m_flag = fv;
        end else if (a) begin
            req = "R2"; m_pc = inc(m_pc);
        end else begin
            req = "R12"; m_arm = arm; m_skip = skp;
        end
        if (n > 1) req = {"R11 ", req};
        @(posedge clk);
        #2;
        compare(req);
    endtask

    initial begin
        #(200000 * 20);
        fails++;
        $display("FAIL watchdog: run did not complete, actual=hung expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        int k;
        void'($urandom(32'd4242));
        adv = 0; setf = 0; lpu = 0; call = 0; ret = 0; irq = 0;
        opnd = 0; flg = 0;
        rst = 1'b1;
        m_pc = '0; m_flag = 1'b1; m_arm = 0; m_skip = 0; m_page = '0;
        for (int i = 0; i < 4; i++) m_st[i] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        compare("R1");
        rst = 1'b0;
        @(negedge clk);
        compare("R1");

        // five nested calls: oldest entry falls off (R4)
        for (int i = 0; i < 5; i++) run(0,0,0,1,0,0, 6'(10 + i), 0);
        // wrap of the address field (R2)
        run(0,0,0,1,0,0, 6'd62, 0);
        run(1,0,0,0,0,0, 0, 0);
        run(1,0,0,0,0,0, 0, 0);
        run(1,0,0,0,0,0, 0, 0);
        // call from address 63 pushes address 0 (R4)
        run(0,0,0,1,0,0, 6'd63, 0);
        run(0,0,0,1,0,0, 6'd5, 0);
        // long call then short call back to page 0 (R6)
        run(0,0,1,0,0,0, 6'd9, 0);
        run(0,0,0,1,0,0, 6'd33, 0);
        run(0,0,0,1,0,0, 6'd34, 0);
        // preload cancelled by an intervening instruction (R6)
        run(0,0,1,0,0,0, 6'd7, 0);
        run(1,0,0,0,0,0, 0, 0);
        run(0,0,0,1,0,0, 6'd1, 0);
        // preload held across an idle cycle (R12)
        run(0,0,1,0,0,0, 6'd3, 0);
        run(0,0,0,0,0,0, 0, 0);
        run(0,0,0,1,0,0, 6'd2, 0);
        // skipped long-call pair (R7)
        run(0,1,0,0,0,0, 0, 0);
        run(0,0,1,0,0,0, 6'd12, 0);
        run(0,0,0,1,0,0, 6'd20, 0);
        // skipped short call (R5) and flag write (R10)
        run(0,1,0,0,0,0, 0, 0);
        run(0,0,0,1,0,0, 6'd21, 0);
        run(0,1,0,0,0,0, 0, 1);
        // interrupt with flag clear (R9)
        run(0,1,0,0,0,0, 0, 0);
        run(0,0,0,0,0,1, 6'd44, 0);
        run(0,1,0,0,0,0, 0, 1);
        // returns past the bottom keep level 4 (R8)
        for (int i = 0; i < 5; i++) run(0,0,0,0,1,0, 0, 0);
        // several strobes together (R11)
        run(1,1,1,1,1,1, 6'd8, 0);
        run(1,1,1,1,0,0, 6'd9, 0);
        run(1,1,0,0,0,0, 6'd9, 0);

        // constrained random mix
        for (int it = 0; it < 4000; it++) begin
            logic [5:0] od;
            od = 6'($urandom);
            k = $urandom % 16;
            case (k)
                0, 1, 2, 3: run(1,0,0,0,0,0, od, 0);
                4:          run(0,1,0,0,0,0, od, 1'($urandom));
                5, 6:       run(0,0,1,0,0,0, od, 0);
                7, 8, 9:    run(0,0,0,1,0,0, od, 0);
                10, 11:     run(0,0,0,0,1,0, od, 0);
                12:         run(0,0,0,0,0,1, od, 0);
                13:         run(0,0,0,0,0,0, od, 0);
                default:    run(1'($urandom), 1'($urandom), 1'($urandom),
                                1'($urandom), 1'($urandom), 1'($urandom),
                                od, 1'($urandom));
            endcase
        end

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule